// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the byte-wide register window through which a host processor controls a graphics coprocessor. It holds a 768-byte space: sixteen 16-bit general registers stored as byte pairs, a two-byte status word, bank and screen-mode bytes, a version byte, a cache base word and a 512-byte instruction cache area. The host reads and writes single bytes. Some of those accesses have side effects on the core, the cache and the interrupt line.

The block starts the core and flushes the cache in response to the run flag in the status word. It marks cache lines valid as the host fills them. It acknowledges the interrupt when the host reads the upper status byte. Two further outputs go to the core: one says whether the core may run, and one tells the address generator that the screen base has changed. The core itself sits outside this block. It talks back through two strobes: one clears the run flag and one raises the interrupt flag.

Top module: `coproc_hostregs`

## Requirements
- R1: Every byte offset from 0x000 to 0x2FF that has no special rule stores the written byte and reads it back unchanged. General register n sits at offsets 2n (low byte) and 2n+1 (high byte). Reads have no side effect, except the read of offset 0x31.
- R2: A host write to offset 0x30 whose bit 5 (the run flag, GO) is 1 while the stored GO is 0 produces a one-cycle `core_start` pulse in the cycle after the write. A write that leaves GO unchanged produces no pulse.
- R3: A host write to offset 0x30 that changes GO from 1 to 0 does three things in the cycle after the write: it gives a one-cycle `cache_flush` pulse, it clears all line-valid flags, and it sets the cache base bytes at 0x3E and 0x3F to zero.
- R4: A host write to offset 0x1F (the high byte of register 15) stores the byte, sets GO and gives a `core_start` pulse, even when GO is already set.
- R5: A read of offset 0x31 returns the stored byte and then clears its bit 7 (the IRQ flag). `host_irq` is low from the next cycle on, unless the core raises the flag again.
- R6: Writes to offsets 0x34 and 0x36 store only bits 6:0, and bit 7 reads 0. Offset 0x3B is the version byte: it reads 0, and writes to it are ignored.
- R7: A write to offset 0x38 sets `geom_dirty`, which stays high until `geom_ack` is pulsed. A write to offset 0x3C drives `ram_bank` with bits 1:0 of the written byte.
- R8: Offsets 0x100 to 0x2FF are the cache area. A write there whose address bits 3:0 are 0xF sets `line_valid[addr[8:4]]`. Any other write there leaves `line_valid` unchanged.
- R9: `run_enable` is high exactly when GO is set and bits 3 and 4 of offset 0x3A are both set. `host_irq` is high exactly when the IRQ flag is set and GO is clear.
- R10: A low `rst_n` at a clock edge zeroes the whole byte space, all line-valid flags, `geom_dirty` and both pulse outputs.
- R11: A `core_clr_go` strobe clears GO and a `core_set_irq` strobe sets the IRQ flag. A host write in the same cycle takes priority over `core_clr_go`. `core_set_irq` takes priority over the read acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | 10 | Host byte offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Stored byte at host_addr, combinational |
| core_clr_go | input | 1 | Core stub: clear the run flag |
| core_set_irq | input | 1 | Core stub: raise the IRQ flag |
| geom_ack | input | 1 | Address generator has taken the new screen base |
| core_start | output | 1 | One-cycle start request to the core |
| cache_flush | output | 1 | One-cycle cache flush to the core |
| run_enable | output | 1 | Core may execute |
| host_irq | output | 1 | Interrupt to the host |
| geom_dirty | output | 1 | Screen base changed |
| ram_bank | output | 2 | RAM bank select |
| line_valid | output | 32 | Per-line cache valid flags |

## Verification
The bench checks the run flag's edges in both directions, and it writes the flag with its current value. A design that starts or flushes on level instead of on change would pulse on that repeated write. It also writes the high byte of register 15 while GO is already set, and a design that gates that start on an edge would miss it.

Line-valid updates are probed with a write to the last byte of a line in each half of the cache area and with a write to a byte just below a line end. Wrong index bits would light the wrong flag.

The interrupt is raised while GO is set, and must stay hidden from the host until the core clears GO. The bench then reads the flag once for its set value and again for its cleared value, which catches an acknowledge that clears the flag too early or never clears it. The bench also checks that the masked offsets drop bit 7 and that the version byte stays zero.

// File: rtl/hr_pkg.sv
// Package: shared offsets, bit positions and the decode record for the
// coprocessor host register window. Assumes a 10-bit byte offset.
package hr_pkg;

    localparam int ADDR_W      = 10;
    localparam int SPACE_BYTES = 768;

    localparam logic [ADDR_W-1:0] OFS_R15_HI   = 10'h01F;
    localparam logic [ADDR_W-1:0] OFS_STAT_LO  = 10'h030;
    localparam logic [ADDR_W-1:0] OFS_STAT_HI  = 10'h031;
    localparam logic [ADDR_W-1:0] OFS_MASK_A   = 10'h034;
    localparam logic [ADDR_W-1:0] OFS_MASK_B   = 10'h036;
    localparam logic [ADDR_W-1:0] OFS_SCR_BASE = 10'h038;
    localparam logic [ADDR_W-1:0] OFS_SCR_MODE = 10'h03A;
    localparam logic [ADDR_W-1:0] OFS_VERSION  = 10'h03B;
    localparam logic [ADDR_W-1:0] OFS_RAM_BANK = 10'h03C;
    localparam logic [ADDR_W-1:0] OFS_CBASE_LO = 10'h03E;
    localparam logic [ADDR_W-1:0] OFS_CBASE_HI = 10'h03F;
    localparam logic [ADDR_W-1:0] OFS_CACHE_LO = 10'h100;

    localparam int BIT_GO  = 5;  // in status low byte
    localparam int BIT_IRQ = 7;  // in status high byte

    typedef struct packed {
        logic in_space;
        logic stat_lo;
        logic stat_hi;
        logic r15_hi;
        logic mask7;
        logic version;
        logic scr_base;
        logic cache;
    } hr_hit_t;

endpackage

// File: rtl/hr_decode.sv
// Module: hr_decode
// Purpose: turns a host byte offset into one flag per special location.
// Assumes: purely combinational, offsets at or above SPACE_BYTES are unmapped.
module hr_decode
    import hr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output hr_hit_t           hit
);

    // Compare the offset against each location with a side effect.
    always_comb begin
        hit          = '0;
        hit.in_space = (int'(addr) < SPACE_BYTES);
        hit.stat_lo  = (addr == OFS_STAT_LO);
        hit.stat_hi  = (addr == OFS_STAT_HI);
        hit.r15_hi   = (addr == OFS_R15_HI);
        hit.mask7    = (addr == OFS_MASK_A) || (addr == OFS_MASK_B);
        hit.version  = (addr == OFS_VERSION);
        hit.scr_base = (addr == OFS_SCR_BASE);
        hit.cache    = hit.in_space && (addr >= OFS_CACHE_LO);
    end

endmodule

// File: rtl/hr_store.sv
// Module: hr_store
// Purpose: byte storage of the whole window with write masking, the run and
// IRQ flag updates from host and core, and the cache base clear on flush.
// Assumes: at most one host access per cycle, flush_req comes from hr_seq.
module hr_store
    import hr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  hr_hit_t           hit,
    input  logic              core_clr_go,
    input  logic              core_set_irq,
    input  logic              flush_req,
    output logic [7:0]        rdata,
    output logic              go,
    output logic              irq_flag,
    output logic [7:0]        scr_mode,
    output logic [7:0]        bank_byte
);

    logic [7:0] mem [SPACE_BYTES];

    // Byte space update: core strobes first, then the host write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SPACE_BYTES; i++) mem[i] <= '0;
        end else begin
            if (core_clr_go)
                mem[OFS_STAT_LO][BIT_GO] <= 1'b0;
            if (rd && hit.stat_hi)
                mem[OFS_STAT_HI][BIT_IRQ] <= 1'b0;
            if (flush_req) begin
                mem[OFS_CBASE_LO] <= '0;
                mem[OFS_CBASE_HI] <= '0;
            end
            if (wr && hit.in_space && !hit.version)
                mem[addr] <= hit.mask7 ? {1'b0, wdata[6:0]} : wdata;
            if (wr && hit.r15_hi)
                mem[OFS_STAT_LO][BIT_GO] <= 1'b1;
            if (core_set_irq)
                mem[OFS_STAT_HI][BIT_IRQ] <= 1'b1;
        end
    end

    // Read port and named views of the control bytes.
    always_comb begin
        rdata     = hit.in_space ? mem[addr] : 8'h00;
        go        = mem[OFS_STAT_LO][BIT_GO];
        irq_flag  = mem[OFS_STAT_HI][BIT_IRQ];
        scr_mode  = mem[OFS_SCR_MODE];
        bank_byte = mem[OFS_RAM_BANK];
    end

    assert_mask7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit.mask7) |=> (mem[$past(addr)][7] == 1'b0));

    assert_version_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr && hit.version) |-> (mem[OFS_VERSION] == 8'h00));

    assert_irq_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit.stat_hi && !core_set_irq) |=> !irq_flag);

    assert_r15_sets_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit.r15_hi) |=> go);

endmodule

// File: rtl/hr_seq.sv
// Module: hr_seq
// Purpose: start and flush pulse generation from run flag edges, per-line
// cache valid flags and the screen geometry dirty flag.
// Assumes: go is the stored run flag before this cycle's write.
module hr_seq
    import hr_pkg::*;
#(
    parameter int LINES      = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  hr_hit_t           hit,
    input  logic              go,
    input  logic              geom_ack,
    output logic              flush_req,
    output logic              core_start,
    output logic              cache_flush,
    output logic              geom_dirty,
    output logic [LINES-1:0]  line_valid
);

    localparam int LSB_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);

    logic             start_req;
    logic             line_end;
    logic [IDX_W-1:0] line_idx;

    // Edge and auto-start detection on the host write.
    always_comb begin
        start_req = wr && ((hit.stat_lo && wdata[BIT_GO] && !go) || hit.r15_hi);
        flush_req = wr && hit.stat_lo && !wdata[BIT_GO] && go;
        line_end  = wr && hit.cache && (&addr[LSB_W-1:0]);
        line_idx  = addr[LSB_W +: IDX_W];
    end

    // Single-cycle pulses toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_start  <= 1'b0;
            cache_flush <= 1'b0;
        end else begin
            core_start  <= start_req;
            cache_flush <= flush_req;
        end
    end

    // Screen geometry dirty flag, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            geom_dirty <= 1'b0;
        else if (wr && hit.scr_base)
            geom_dirty <= 1'b1;
        else if (geom_ack)
            geom_dirty <= 1'b0;
    end

    // One valid flag per cache line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n || flush_req)
                line_valid[g] <= 1'b0;
            else if (line_end && (line_idx == IDX_W'(g)))
                line_valid[g] <= 1'b1;
        end
    end

    assert_pulse_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_start && cache_flush));

    assert_flush_clears_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cache_flush |-> (line_valid == '0));

    assert_start_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> go);

    assert_geom_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit.scr_base) |=> geom_dirty);

endmodule

// File: rtl/coproc_hostregs.sv
// Module: coproc_hostregs
// Purpose: host-side byte register window of a graphics coprocessor; joins
// decode, storage and sequencing, and forms run enable and host interrupt.
// Assumes: one host access per cycle, synchronous active-low reset.
module coproc_hostregs
    import hr_pkg::*;
#(
    parameter int LINES      = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              core_clr_go,
    input  logic              core_set_irq,
    input  logic              geom_ack,
    output logic              core_start,
    output logic              cache_flush,
    output logic              run_enable,
    output logic              host_irq,
    output logic              geom_dirty,
    output logic [1:0]        ram_bank,
    output logic [LINES-1:0]  line_valid
);

    hr_hit_t    hit;
    logic       go;
    logic       irq_flag;
    logic       flush_req;
    logic [7:0] scr_mode;
    logic [7:0] bank_byte;

    hr_decode u_decode (
        .addr (host_addr),
        .hit  (hit)
    );

    hr_store u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (host_wr),
        .rd           (host_rd),
        .addr         (host_addr),
        .wdata        (host_wdata),
        .hit          (hit),
        .core_clr_go  (core_clr_go),
        .core_set_irq (core_set_irq),
        .flush_req    (flush_req),
        .rdata        (host_rdata),
        .go           (go),
        .irq_flag     (irq_flag),
        .scr_mode     (scr_mode),
        .bank_byte    (bank_byte)
    );

    hr_seq #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (host_wr),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .hit         (hit),
        .go          (go),
        .geom_ack    (geom_ack),
        .flush_req   (flush_req),
        .core_start  (core_start),
        .cache_flush (cache_flush),
        .geom_dirty  (geom_dirty),
        .line_valid  (line_valid)
    );

    // Run permission, host interrupt and bank select from stored bytes.
    always_comb begin
        run_enable = go && scr_mode[3] && scr_mode[4];
        host_irq   = irq_flag && !go;
        ram_bank   = bank_byte[1:0];
    end

endmodule

// File: tb/coproc_hostregs_tb.sv
module coproc_hostregs_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        core_clr_go = 1'b0;
    logic        core_set_irq = 1'b0;
    logic        geom_ack = 1'b0;
    logic        core_start, cache_flush, run_enable, host_irq, geom_dirty;
    logic [1:0]  ram_bank;
    logic [31:0] line_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic st_seen, fl_seen;
    logic [7:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    coproc_hostregs u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_clr_go(core_clr_go), .core_set_irq(core_set_irq), .geom_ack(geom_ack),
        .core_start(core_start), .cache_flush(cache_flush), .run_enable(run_enable),
        .host_irq(host_irq), .geom_dirty(geom_dirty), .ram_bank(ram_bank),
        .line_valid(line_valid)
    );

    // {is_read, offset, data-or-expected}
    localparam logic [18:0] VEC [16] = '{
        {1'b0, 10'h000, 8'h34}, {1'b1, 10'h000, 8'h34},
        {1'b0, 10'h001, 8'h12}, {1'b1, 10'h001, 8'h12},
        {1'b0, 10'h034, 8'hFF}, {1'b1, 10'h034, 8'h7F},
        {1'b0, 10'h036, 8'h80}, {1'b1, 10'h036, 8'h00},
        {1'b0, 10'h03B, 8'h55}, {1'b1, 10'h03B, 8'h00},
        {1'b0, 10'h150, 8'hAB}, {1'b1, 10'h150, 8'hAB},
        {1'b0, 10'h020, 8'h99}, {1'b1, 10'h020, 8'h99},
        {1'b0, 10'h03C, 8'h07}, {1'b1, 10'h03C, 8'h07}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        st_seen = core_start;
        fl_seen = cache_flush;
    endtask

    task automatic rd(input logic [9:0] a);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 rd_val = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic strobe_clr_go();
        @(negedge clk); core_clr_go = 1'b1;
        @(negedge clk); core_clr_go = 1'b0;
    endtask

    task automatic strobe_set_irq();
        @(negedge clk); core_set_irq = 1'b1;
        @(negedge clk); core_set_irq = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state
        rd(10'h000); check("R10 reg0", rd_val, 8'h00);
        rd(10'h030); check("R10 status", rd_val, 8'h00);
        check("R10 lines", line_valid, 32'h0);
        check("R10 irq", host_irq, 1'b0);
        check("R10 start", core_start, 1'b0);

        // R1 / R6 / R7 table walk
        foreach (VEC[i]) begin
            if (VEC[i][18]) begin
                rd(VEC[i][17:8]);
                check("R1/R6 table read", rd_val, VEC[i][7:0]);
            end else begin
                wr(VEC[i][17:8], VEC[i][7:0]);
            end
        end
        check("R7 ram_bank", ram_bank, 2'd3);

        // R2: GO rise gives one start, repeat gives none
        wr(10'h030, 8'h20);
        check("R2 start on rise", st_seen, 1'b1);
        check("R2 no flush on rise", fl_seen, 1'b0);
        @(negedge clk); check("R2 pulse one cycle", core_start, 1'b0);
        wr(10'h030, 8'h20);
        check("R2 no start unchanged", st_seen, 1'b0);

        // R9: run enable
        wr(10'h03A, 8'h18); check("R9 run on", run_enable, 1'b1);
        wr(10'h03A, 8'h08); check("R9 run off", run_enable, 1'b0);

        // R8: line valid flags
        wr(10'h10F, 8'h01); check("R8 line16", line_valid, 32'h0001_0000);
        wr(10'h20F, 8'h02); check("R8 line0", line_valid, 32'h0001_0001);
        wr(10'h21E, 8'h03); check("R8 non-end", line_valid, 32'h0001_0001);

        // R3: GO fall flushes
        wr(10'h03E, 8'h40);
        wr(10'h03F, 8'h12);
        wr(10'h030, 8'h00);
        check("R3 flush pulse", fl_seen, 1'b1);
        check("R3 no start", st_seen, 1'b0);
        check("R3 lines clear", line_valid, 32'h0);
        rd(10'h03E); check("R3 base lo", rd_val, 8'h00);
        rd(10'h03F); check("R3 base hi", rd_val, 8'h00);

        // R4: high byte of R15 auto-starts, also with GO set
        wr(10'h01F, 8'h80);
        check("R4 start", st_seen, 1'b1);
        rd(10'h030); check("R4 go set", rd_val[5], 1'b1);
        rd(10'h01F); check("R4 stored", rd_val, 8'h80);
        wr(10'h01F, 8'h81);
        check("R4 start go already set", st_seen, 1'b1);

        // R11 / R9 / R5: IRQ hidden while GO set, ack on read
        strobe_set_irq();
        check("R9 irq masked by go", host_irq, 1'b0);
        strobe_clr_go();
        check("R11 go cleared", host_irq, 1'b1);
        rd(10'h031); check("R5 read irq set", rd_val, 8'h80);
        check("R5 irq deasserted", host_irq, 1'b0);
        rd(10'h031); check("R5 bit cleared", rd_val, 8'h00);

        // R7: geometry dirty
        wr(10'h038, 8'h05); check("R7 dirty set", geom_dirty, 1'b1);
        @(negedge clk) geom_ack = 1'b1;
        @(negedge clk) geom_ack = 1'b0;
        check("R7 dirty ack", geom_dirty, 1'b0);

        // R10: reset mid-run
        wr(10'h10F, 8'h11);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R10 lines after reset", line_valid, 32'h0);
        rd(10'h000); check("R10 reg0 after reset", rd_val, 8'h00);
        rd(10'h10F); check("R10 cache after reset", rd_val, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule